// File: doc/BRIEF.md
# Serial Configuration Chain Loader

This block is a slave on a simple register bus. It loads a long serial configuration chain inside an external front-end chip. Software fills a bank of 32-bit transmit words and then writes a single control word. That write starts a transfer and also chooses whether the external chain is cleared first. The block then enters a reset phase, in which it asserts the chain's load strobe and, on request, drives its active-low reset. After that it shifts out a parameterised number of bits on a gated serial clock. The serial clock is derived from the system clock by a divider.

While bits go out, the bit that returns from the far end of the chain is sampled on every serial rising edge. It is written into a read-only receive bank at the same bit index. After a transfer, the receive bank therefore holds what the chain contained before it was overwritten. A busy flag in the control word tells software when the transfer has finished. The bit count need not be a multiple of 32.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset the bus ack is low, the serial clock and load are low, the chain reset is high (inactive), and the control word reads 0.
- R2: Bus offsets 0x00 to 0x1F are read/write transmit words; a word written there reads back unchanged.
- R3: Offsets 0x20 to 0x3F are read-only receive words; a bus write there has no effect on what they read back, and receive bits at or above the bit count read 0.
- R4: A write to offset 0x40 while idle starts a transfer. Write-data bit 0 is latched: 0 drives the chain reset low throughout the reset phase, and 1 keeps it high for the whole transfer. Outside the reset phase the chain reset is always high.
- R5: Load is high only during the reset phase, which comes before any serial clock edge; the serial clock stays low while load is high.
- R6: Each transfer produces exactly NBITS rising edges of the serial clock, and the data output changes only while the serial clock is low.
- R7: Transmit bit i (bit i mod 32 of word i/32) is the data output at the i-th serial rising edge (counting from 0), so bit 0 of word 0 goes first.
- R8: The chain input sampled at the i-th serial rising edge is stored at receive bit i. With no chain reset, receive bit i equals the chain's content that was i places from its output end before the transfer. With a chain reset, the receive bank reads all zero.
- R9: Bit 0 of the control word reads 1 while a transfer is in progress and 0 after the last bit; the serial clock is low and load is low when idle.
- R10: A control write made while busy is ignored: it neither restarts the transfer nor changes the latched reset choice.
- R11: The bus ack is a one-cycle pulse following each strobe; with the strobe held, ack alternates high and low, and each ack completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write enable (1 = write) |
| bus_addr | input | WORDS_LOG2+2 | Bus word offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid while bus_ack is high |
| bus_ack | output | 1 | Single-cycle access acknowledge |
| chain_sclk | output | 1 | Gated serial clock to the chain |
| chain_sdo | output | 1 | Serial data to the chain |
| chain_sdi | input | 1 | Serial data returning from the chain |
| chain_rst_n | output | 1 | Active-low chain reset |
| chain_load | output | 1 | Chain load strobe, high during the reset phase |

## Verification
The bench runs three transfers against a behavioural model of the chain, which shifts on each serial rising edge. The first transfer starts from a preloaded chain pattern with no reset, so the receive bank must show that pattern in reversed order; a redundant control write during this transfer must change nothing. The second transfer requests a reset, so the receive bank must read zero, which tells a reset chain apart from a merely overwritten one. The third transfer goes without a reset and must return exactly the bits sent by the second, which checks the transmit bit order and the receive bit order together. Bank reads, writes into the read-only area, and a held strobe cover the bus side.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_SHIFT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/chain_clk_div.sv
// Free-running divider: one phase toggle every HALF_DIV system cycles,
// with one-cycle pulses marking the coming rising and falling serial edges.
module chain_clk_div #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic rise_p,
  output logic fall_p
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          tick;

  assign tick   = (cnt_q == CNT_LAST);
  assign rise_p = tick & ~phase_q;
  assign fall_p = tick & phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chain_bus_regs.sv
// Bus slave: transmit bank, receive bank read port, control/status word.
module chain_bus_regs
  import cfg_chain_pkg::*;
#(
  parameter int unsigned WORDS_LOG2 = 5,
  localparam int unsigned NWORDS = 1 << WORDS_LOG2,
  localparam int unsigned ADDR_W = WORDS_LOG2 + 2,
  localparam int unsigned TOT    = NWORDS * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              ack,
  input  logic              busy,
  input  logic [TOT-1:0]    rx_bank,
  output logic [TOT-1:0]    tx_bank,
  output logic              start_p,
  output logic              pre_rst_n
);
  localparam logic [1:0] REG_TX = 2'b00;
  localparam logic [1:0] REG_RX = 2'b01;

  logic [NWORDS-1:0][BUS_W-1:0] tx_q;
  logic [NWORDS-1:0][BUS_W-1:0] rx_w;
  logic [1:0]                   region;
  logic [WORDS_LOG2-1:0]        word_sel;
  logic                         wr_fire;

  assign rx_w     = rx_bank;
  assign tx_bank  = tx_q;
  assign region   = addr[ADDR_W-1:ADDR_W-2];
  assign word_sel = addr[WORDS_LOG2-1:0];
  assign wr_fire  = stb & we & ~ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack       <= 1'b0;
      start_p   <= 1'b0;
      pre_rst_n <= 1'b1;
      tx_q      <= '0;
    end else begin
      ack     <= stb & ~ack;
      start_p <= 1'b0;
      if (wr_fire) begin
        case (region)
          REG_TX:  tx_q[word_sel] <= wdata;
          REG_RX:  ;
          default: begin
            if (!busy) begin
              start_p   <= 1'b1;
              pre_rst_n <= wdata[0];
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (region)
      REG_TX:  rdata = tx_q[word_sel];
      REG_RX:  rdata = rx_w[word_sel];
      default: rdata = {{(BUS_W-1){1'b0}}, busy};
    endcase
  end
endmodule

// File: rtl/chain_seq.sv
// Transfer sequencer: reset phase, then NBITS serial bits out and back.
module chain_seq
  import cfg_chain_pkg::*;
#(
  parameter int unsigned NBITS = 829,
  parameter int unsigned TOT   = 1024
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_p,
  input  logic           pre_rst_n,
  input  logic           rise_p,
  input  logic           fall_p,
  input  logic [TOT-1:0] tx_bank,
  input  logic           sdi,
  output logic           sclk,
  output logic           sdo,
  output logic           chain_rst_n,
  output logic           load,
  output logic           busy,
  output logic [TOT-1:0] rx_bank
);
  localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

  seq_state_t     state_q;
  logic [IDX_W-1:0] idx_q;
  logic           seen_rise_q;
  logic           sclk_q;
  logic [TOT-1:0] rx_q;

  assign busy        = (state_q != SEQ_IDLE);
  assign load        = (state_q == SEQ_RESET);
  assign chain_rst_n = (state_q == SEQ_RESET) ? pre_rst_n : 1'b1;
  assign sclk        = sclk_q;
  assign sdo         = (state_q == SEQ_SHIFT) ? tx_bank[idx_q] : 1'b0;
  assign rx_bank     = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      idx_q       <= '0;
      seen_rise_q <= 1'b0;
      sclk_q      <= 1'b0;
      rx_q        <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          sclk_q <= 1'b0;
          if (start_p) begin
            state_q     <= SEQ_RESET;
            seen_rise_q <= 1'b0;
          end
        end
        SEQ_RESET: begin
          if (rise_p) seen_rise_q <= 1'b1;
          if (fall_p && seen_rise_q) begin
            state_q <= SEQ_SHIFT;
            idx_q   <= '0;
          end
        end
        SEQ_SHIFT: begin
          if (rise_p) begin
            sclk_q      <= 1'b1;
            rx_q[idx_q] <= sdi;
          end
          if (fall_p) begin
            sclk_q <= 1'b0;
            if (idx_q == IDX_LAST) state_q <= SEQ_IDLE;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
  import cfg_chain_pkg::*;
#(
  parameter int unsigned WORDS_LOG2 = 5,
  parameter int unsigned NBITS      = 829,
  parameter int unsigned HALF_DIV   = 4,
  localparam int unsigned ADDR_W = WORDS_LOG2 + 2,
  localparam int unsigned TOT    = (1 << WORDS_LOG2) * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ack,
  output logic              chain_sclk,
  output logic              chain_sdo,
  input  logic              chain_sdi,
  output logic              chain_rst_n,
  output logic              chain_load
);
  logic           rise_p, fall_p;
  logic           start_p, pre_rst_n, seq_busy;
  logic [TOT-1:0] tx_bank, rx_bank;

  chain_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .rise_p(rise_p), .fall_p(fall_p)
  );

  chain_bus_regs #(.WORDS_LOG2(WORDS_LOG2)) u_regs (
    .clk(clk), .rst(rst), .stb(bus_stb), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ack(bus_ack), .busy(seq_busy),
    .rx_bank(rx_bank), .tx_bank(tx_bank), .start_p(start_p),
    .pre_rst_n(pre_rst_n)
  );

  chain_seq #(.NBITS(NBITS), .TOT(TOT)) u_seq (
    .clk(clk), .rst(rst), .start_p(start_p), .pre_rst_n(pre_rst_n),
    .rise_p(rise_p), .fall_p(fall_p), .tx_bank(tx_bank), .sdi(chain_sdi),
    .sclk(chain_sclk), .sdo(chain_sdo), .chain_rst_n(chain_rst_n),
    .load(chain_load), .busy(seq_busy), .rx_bank(rx_bank)
  );
endmodule

// File: rtl/cfg_chain_loader_chk.sv
module cfg_chain_loader_chk (
  input logic clk,
  input logic rst,
  input logic bus_stb,
  input logic bus_ack,
  input logic chain_sclk,
  input logic chain_sdo,
  input logic chain_load,
  input logic chain_rst_n,
  input logic busy
);
  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);
  // R11
  ack_follows_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_ack) |=> bus_ack);
  // R5
  load_no_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    chain_load |-> (busy && !chain_sclk));
  // R4
  rst_in_load_chk: assert property (@(posedge clk) disable iff (rst)
    !chain_rst_n |-> chain_load);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!chain_sclk && !chain_load));
  // R6
  sdo_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (chain_sclk && $past(chain_sclk)) |-> $stable(chain_sdo));
  // R10
  load_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(chain_load) |-> $past(!busy));
endmodule

bind cfg_chain_loader cfg_chain_loader_chk u_chk (
  .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_ack(bus_ack),
  .chain_sclk(chain_sclk), .chain_sdo(chain_sdo), .chain_load(chain_load),
  .chain_rst_n(chain_rst_n), .busy(seq_busy)
);

// File: tb/cfg_chain_loader_test.sv
`timescale 1ns/1ps
module cfg_chain_loader_test;
  localparam int NB  = 70;
  localparam int TOT = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_stb = 1'b0, bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, chain_sclk, chain_sdo, chain_sdi, chain_rst_n, chain_load;

  always #5 clk = ~clk;

  cfg_chain_loader #(.WORDS_LOG2(5), .NBITS(NB), .HALF_DIV(2)) uut (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .chain_sclk(chain_sclk), .chain_sdo(chain_sdo),
    .chain_sdi(chain_sdi), .chain_rst_n(chain_rst_n), .chain_load(chain_load)
  );

  int checks = 0, errors = 0;
  // behavioural external chain and per-clock monitor state
  logic [NB-1:0] chain = '0;
  logic [NB-1:0] preload_val = '0;
  logic          preload_req = 1'b0;
  logic          sclk_prev = 1'b0;
  logic [NB-1:0] exp_tx = '0;
  logic [31:0]   txw [0:2];
  int edge_cnt = 0, bit_err = 0, viol = 0, rst_seen = 0, load_seen = 0;

  assign chain_sdi = chain[NB-1];

  always @(posedge clk) begin
    sclk_prev <= chain_sclk;
    if (preload_req) chain <= preload_val;
    else if (!chain_rst_n) chain <= '0;
    else if (chain_sclk && !sclk_prev) begin
      chain <= {chain[NB-2:0], chain_sdo};
      if (edge_cnt >= NB || chain_sdo !== exp_tx[edge_cnt]) bit_err++;
      edge_cnt++;
    end
    if (!rst) begin
      if (!chain_rst_n) rst_seen = 1;
      if (chain_load) load_seen = 1;
      if (chain_load && chain_sclk) viol++;
      if (!chain_rst_n && !chain_load) viol++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    if (bus_ack !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R11 write ack actual=%b expected=1", bus_ack);
    end
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    if (bus_ack !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R11 read ack actual=%b expected=1", bus_ack);
    end
    bus_stb = 1'b0;
  endtask

  task automatic load_tx(input logic [31:0] w0, w1, w2);
    txw[0] = w0; txw[1] = w1; txw[2] = w2;
    bus_write(7'h00, w0); bus_write(7'h01, w1); bus_write(7'h02, w2);
  endtask

  task automatic run_xfer(input bit do_reset, input bit poke_busy, input string tag);
    logic [NB-1:0]  pre;
    logic [TOT-1:0] er;
    logic [31:0]    d;
    pre = chain;
    for (int i = 0; i < NB; i++) exp_tx[i] = txw[i / 32][i % 32];
    er = '0;
    for (int k = 0; k < NB; k++) er[k] = do_reset ? 1'b0 : pre[NB-1-k];
    edge_cnt = 0; bit_err = 0; viol = 0; rst_seen = 0; load_seen = 0;
    bus_write(7'h40, do_reset ? 32'h0 : 32'h1);
    bus_read(7'h40, d);
    check({tag, " R9 busy during transfer"}, d, 32'h1);
    if (poke_busy) bus_write(7'h40, 32'h0);  // R10: ignored while busy
    for (int i = 0; i < 5000; i++) begin
      bus_read(7'h40, d);
      if (d[0] == 1'b0) break;
    end
    check({tag, " R9 busy clears"}, d, 32'h0);
    check({tag, " R6 serial edge count"}, edge_cnt, NB);
    check({tag, " R7 bit order mismatches"}, bit_err, 0);
    check({tag, poke_busy ? " R10 R4 reset seen" : " R4 reset seen"}, rst_seen, do_reset ? 1 : 0);
    check({tag, " R5 load seen"}, load_seen, 1);
    check({tag, " R5 per-clock violations"}, viol, 0);
    for (int w = 0; w < 4; w++) begin
      bus_read(7'(32 + w), d);
      check({tag, " R8 receive word"}, d, er[w*32 +: 32]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        a0, a1, a2, a3;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ack", bus_ack, 0);
    check("R1 sclk", chain_sclk, 0);
    check("R1 load", chain_load, 0);
    check("R1 chain reset", chain_rst_n, 1);
    bus_read(7'h40, d);
    check("R1 status", d, 0);

    // R2 transmit bank
    load_tx(32'hA5C3_0F17, 32'h1234_9876, 32'hFFFF_FFC5);
    bus_write(7'h1F, 32'h0BAD_F00D);
    bus_read(7'h00, d); check("R2 word0", d, 32'hA5C3_0F17);
    bus_read(7'h02, d); check("R2 word2", d, 32'hFFFF_FFC5);
    bus_read(7'h1F, d); check("R2 word31", d, 32'h0BAD_F00D);

    // R3 receive bank is read-only
    bus_write(7'h20, 32'hDEAD_BEEF);
    bus_read(7'h20, d); check("R3 write ignored", d, 32'h0);

    // R11 held strobe: ack alternates
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_addr = 7'h00;
    @(negedge clk); a0 = bus_ack;
    @(negedge clk); a1 = bus_ack;
    @(negedge clk); a2 = bus_ack;
    @(negedge clk); a3 = bus_ack;
    bus_stb = 1'b0;
    check("R11 held strobe ack pattern", {28'h0, a0, a1, a2, a3}, 32'hA);

    // Transfer A: preloaded chain, no reset, redundant control write while busy
    @(negedge clk);
    preload_val = {6'h2D, 32'hDEAD_BEEF, 32'h0137_C0DE};
    preload_req = 1'b1;
    @(negedge clk);
    preload_req = 1'b0;
    run_xfer(1'b0, 1'b1, "A");

    // R3 after capture: write into receive area leaves data intact
    bus_read(7'h21, d);
    bus_write(7'h21, ~d);
    begin
      logic [31:0] d2;
      bus_read(7'h21, d2);
      check("R3 capture unchanged by write", d2, d);
    end

    // Transfer B: chain reset first
    load_tx(32'h0F0F_3C3C, 32'h8000_0001, 32'h0000_0015);
    run_xfer(1'b1, 1'b0, "B");

    // Transfer C: no reset, returns what B sent (R8)
    load_tx(32'h7777_1111, 32'h5A5A_A5A5, 32'h0000_0033);
    run_xfer(1'b0, 1'b0, "C");
    @(negedge clk);
    check("R9 idle sclk", chain_sclk, 0);
    check("R9 idle load", chain_load, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule